// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small datapath built around one internal bus. Four general registers, an address register and a data register all hang on that bus. Each accepted command puts exactly one source on the bus through a multiplexer. A decoded destination field then raises the load enables of the registers that capture the bus value on the next clock edge. A command may name a second destination slot. Both slots must then name the same source, so that one bus value can fill two registers in the same cycle.

The address and data registers connect the bus to an external synchronous memory port. A memory write stores the data register at the address held in the address register. A memory read fills the data register from that address. The memory can stretch any access with wait states: the port keeps its request, address and write data steady until the ready input comes back high.

The controller has two states. In `FSM_IDLE` it accepts commands. A register move, or a rejected command, finishes in place with a done pulse. A legal memory command takes the transition *start access* to `FSM_WAIT`. In `FSM_WAIT` the memory request is held high. The transition *memory acknowledged*, taken when `mem_ready` is sampled high, returns the controller to `FSM_IDLE` and pulses done.

Top module: `busxfer_top`

## Requirements
- R1: A synchronous active-high reset clears every register (general, address, data), `busy`, `done`, `illegal` and `xfer_data` to zero.
- R2: Source code 0 to 3 places general register 0 to 3 on the bus, 4 the address register, 5 the data register, and 6 the `cmd_imm` field. A move (op 0) loads its destinations at the edge that accepts it, and `done` is high in the cycle after that edge, with `xfer_data` equal to the bus value.
- R3: Destination codes 0 to 3 select the general registers, 4 the address register and 5 the data register; code 7 loads nothing. With `cmd_pair` high, the second slot's destination loads the same bus value in the same cycle, so at most two load enables are active at once.
- R4: A move whose pair names a source different from `src_a`, or that uses source code 7 or destination code 6, is illegal. It changes no register, and it pulses `done` together with `illegal`, with `xfer_data` equal to 0.
- R5: Op 1 writes the data register to memory at the address register. `done` comes W+2 cycles after the issuing cycle, where W is the number of cycles the memory holds ready low. `xfer_data` equals the written value.
- R6: Op 2 loads the data register from memory at the address register. The value is captured at the edge where ready is high, and `xfer_data` equals the value read.
- R7: While a request waits for ready, `mem_req`, `mem_addr`, `mem_wdata` and `mem_we` stay unchanged.
- R8: `busy` is high exactly while a memory access is outstanding. `done` is high only in the cycle after an accepted command or a memory acknowledge.
- R9: Commands presented while `busy` is high are ignored: no register loads and no extra `done`.
- R10: Op code 3 is reserved. It is rejected as illegal, in the same way as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 move, 1 memory write, 2 memory read, 3 reserved |
| cmd_src_a | input | 3 | Bus source code |
| cmd_dst_a | input | 3 | First destination code |
| cmd_pair | input | 1 | Second destination slot in use |
| cmd_src_b | input | 3 | Source named by the second slot (must equal `cmd_src_a`) |
| cmd_dst_b | input | 3 | Second destination code |
| cmd_imm | input | 8 | Immediate value, bus source 6 |
| busy | output | 1 | Memory access outstanding |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completed command was rejected |
| xfer_data | output | 8 | Value moved by the completed command |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address (address register) |
| mem_wdata | output | 8 | Memory write data (data register) |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory acknowledge, sampled each cycle |

## Verification
The assertions assume a memory that answers every request with ready after a finite number of cycles, and whose read data is valid in the cycle ready is high. The bench's memory model counts a programmable number of wait cycles before it raises ready. It serves reads from its array combinationally and commits writes only at the acknowledging edge. The driver normally waits for each command to finish before sending the next one. The single exception is a deliberate burst of commands issued while busy, used to show they are dropped.

// File: rtl/busxfer_pkg.sv
package busxfer_pkg;
    localparam int NUM_GPR = 4;
    localparam int SEL_W   = 3;
    localparam int NUM_DST = NUM_GPR + 2;
    localparam int IDX_W   = $clog2(NUM_GPR);

    localparam logic [SEL_W-1:0] SEL_AR   = SEL_W'(NUM_GPR);
    localparam logic [SEL_W-1:0] SEL_DR   = SEL_W'(NUM_GPR + 1);
    localparam logic [SEL_W-1:0] SEL_IMM  = SEL_W'(NUM_GPR + 2);
    localparam logic [SEL_W-1:0] SEL_RSVD = SEL_W'(NUM_GPR + 3);
    localparam logic [SEL_W-1:0] DST_RSVD = SEL_W'(NUM_GPR + 2);
    localparam logic [SEL_W-1:0] DST_NONE = SEL_W'(NUM_GPR + 3);

    typedef enum logic [1:0] {
        OP_MOVE   = 2'd0,
        OP_MWRITE = 2'd1,
        OP_MREAD  = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_WAIT = 1'b1
    } fsm_e;
endpackage

// File: rtl/busxfer_decode.sv
module busxfer_decode
    import busxfer_pkg::*;
(
    input  logic               accept,
    input  logic [1:0]         op,
    input  logic [SEL_W-1:0]   src_a,
    input  logic [SEL_W-1:0]   dst_a,
    input  logic               pair,
    input  logic [SEL_W-1:0]   src_b,
    input  logic [SEL_W-1:0]   dst_b,
    output logic               bad,
    output logic               is_move,
    output logic               is_wr,
    output logic               is_rd,
    output logic [NUM_DST-1:0] ld_vec
);
    logic [NUM_DST-1:0] hit_a;
    logic [NUM_DST-1:0] hit_b;
    logic               move_bad;

    // one decoder per slot: each destination code raises one enable
    for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
        assign hit_a[d] = (dst_a == SEL_W'(d));
        assign hit_b[d] = pair && (dst_b == SEL_W'(d));
    end

    always_comb begin
        is_move  = (op == OP_MOVE);
        is_wr    = (op == OP_MWRITE);
        is_rd    = (op == OP_MREAD);
        move_bad = (src_a == SEL_RSVD) || (dst_a == DST_RSVD)
                   || (pair && ((src_b != src_a) || (dst_b == DST_RSVD)));
        bad      = (op == OP_RSVD) || (is_move && move_bad);
        ld_vec   = '0;
        if (accept && is_move && !bad) begin
            ld_vec = hit_a | hit_b;
        end
    end
endmodule

// File: rtl/busxfer_regfile.sv
module busxfer_regfile
    import busxfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   bus_sel,
    input  logic [DATA_W-1:0]  imm,
    input  logic [NUM_DST-1:0] ld_vec,
    input  logic               ld_dr_mem,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  bus_val,
    output logic [DATA_W-1:0]  ar_q,
    output logic [DATA_W-1:0]  dr_q
);
    localparam int AR_BIT = NUM_GPR;
    localparam int DR_BIT = NUM_GPR + 1;

    logic [DATA_W-1:0] gpr_q [NUM_GPR];

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (rst) begin
                gpr_q[g] <= '0;
            end else if (ld_vec[g]) begin
                gpr_q[g] <= bus_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else if (ld_vec[AR_BIT]) begin
            ar_q <= bus_val;
        end
    end

    // memory capture and bus load never coincide: loads happen only when idle
    always_ff @(posedge clk) begin
        if (rst) begin
            dr_q <= '0;
        end else if (ld_dr_mem) begin
            dr_q <= mem_rdata;
        end else if (ld_vec[DR_BIT]) begin
            dr_q <= bus_val;
        end
    end

    // single bus source: one multiplexer, no shared drivers
    always_comb begin
        bus_val = '0;
        if (bus_sel < SEL_W'(NUM_GPR)) begin
            bus_val = gpr_q[bus_sel[IDX_W-1:0]];
        end else if (bus_sel == SEL_AR) begin
            bus_val = ar_q;
        end else if (bus_sel == SEL_DR) begin
            bus_val = dr_q;
        end else if (bus_sel == SEL_IMM) begin
            bus_val = imm;
        end
    end
endmodule

// File: rtl/busxfer_ctrl.sv
module busxfer_ctrl
    import busxfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              is_move,
    input  logic              is_wr,
    input  logic              is_rd,
    input  logic              bad,
    input  logic [DATA_W-1:0] bus_val,
    input  logic [DATA_W-1:0] dr_q,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              accept,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              ld_dr_mem,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] xfer_data
);
    fsm_e state_q, state_d;
    logic we_q;

    always_comb begin
        accept  = cmd_valid && (state_q == FSM_IDLE);
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: if (accept && !bad && (is_wr || is_rd)) state_d = FSM_WAIT;
            FSM_WAIT: if (mem_ready) state_d = FSM_IDLE;
            default:  state_d = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FSM_IDLE;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) we_q <= is_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            illegal   <= 1'b0;
            xfer_data <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            unique case (state_q)
                FSM_IDLE: begin
                    if (accept && bad) begin
                        done      <= 1'b1;
                        illegal   <= 1'b1;
                        xfer_data <= '0;
                    end else if (accept && is_move) begin
                        done      <= 1'b1;
                        xfer_data <= bus_val;
                    end
                end
                FSM_WAIT: begin
                    if (mem_ready) begin
                        done      <= 1'b1;
                        xfer_data <= we_q ? dr_q : mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q == FSM_WAIT);
        mem_req   = busy;
        mem_we    = busy && we_q;
        ld_dr_mem = busy && mem_ready && !we_q;
    end
endmodule

// File: rtl/busxfer_top.sv
module busxfer_top
    import busxfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [2:0]        cmd_src_a,
    input  logic [2:0]        cmd_dst_a,
    input  logic              cmd_pair,
    input  logic [2:0]        cmd_src_b,
    input  logic [2:0]        cmd_dst_b,
    input  logic [DATA_W-1:0] cmd_imm,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] xfer_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    logic               accept;
    logic               bad;
    logic               is_move;
    logic               is_wr;
    logic               is_rd;
    logic               ld_dr_mem;
    logic [NUM_DST-1:0] ld_vec;
    logic [DATA_W-1:0]  bus_val;
    logic [DATA_W-1:0]  ar_q;
    logic [DATA_W-1:0]  dr_q;

    busxfer_decode u_decode (
        .accept  (accept),
        .op      (cmd_op),
        .src_a   (cmd_src_a),
        .dst_a   (cmd_dst_a),
        .pair    (cmd_pair),
        .src_b   (cmd_src_b),
        .dst_b   (cmd_dst_b),
        .bad     (bad),
        .is_move (is_move),
        .is_wr   (is_wr),
        .is_rd   (is_rd),
        .ld_vec  (ld_vec)
    );

    busxfer_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (cmd_src_a),
        .imm       (cmd_imm),
        .ld_vec    (ld_vec),
        .ld_dr_mem (ld_dr_mem),
        .mem_rdata (mem_rdata),
        .bus_val   (bus_val),
        .ar_q      (ar_q),
        .dr_q      (dr_q)
    );

    busxfer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .is_move   (is_move),
        .is_wr     (is_wr),
        .is_rd     (is_rd),
        .bad       (bad),
        .bus_val   (bus_val),
        .dr_q      (dr_q),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .accept    (accept),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .ld_dr_mem (ld_dr_mem),
        .done      (done),
        .illegal   (illegal),
        .xfer_data (xfer_data)
    );

    assign mem_addr  = ar_q;
    assign mem_wdata = dr_q;
endmodule

// File: rtl/busxfer_chk.sv
module busxfer_chk
    import busxfer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               busy,
    input logic               done,
    input logic               illegal,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic [DATA_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic [DATA_W-1:0]  ar_q,
    input logic [DATA_W-1:0]  dr_q,
    input logic [NUM_DST-1:0] ld_vec
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && ar_q == '0 && dr_q == '0));

    // R3
    load_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ld_vec) <= 2);

    // R4
    illegal_done_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    // R6
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !mem_we) |=> (dr_q == $past(mem_rdata)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_wdata) && $stable(mem_we)));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(cmd_valid) || $past(mem_ready)));

    // R9
    no_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ld_vec == '0));
endmodule

bind busxfer_top busxfer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .ar_q      (ar_q),
    .dr_q      (dr_q),
    .ld_vec    (ld_vec)
);

// File: tb/busxfer_top_tb_top.sv
module busxfer_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [2:0] cmd_src_a = '0, cmd_dst_a = '0, cmd_src_b = '0, cmd_dst_b = '0;
    logic       cmd_pair = 1'b0;
    logic [7:0] cmd_imm = '0;
    logic       busy, done, illegal, mem_req, mem_we, mem_ready;
    logic [7:0] xfer_data, mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busxfer_top dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_src_a(cmd_src_a), .cmd_dst_a(cmd_dst_a), .cmd_pair(cmd_pair),
        .cmd_src_b(cmd_src_b), .cmd_dst_b(cmd_dst_b), .cmd_imm(cmd_imm),
        .busy(busy), .done(done), .illegal(illegal), .xfer_data(xfer_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory with programmable wait states
    logic [7:0] mem_arr [256];
    int         mem_wait = 0;
    int         wait_cnt = 0;
    assign mem_ready = mem_req && (wait_cnt == mem_wait);
    assign mem_rdata = mem_arr[mem_addr];
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            wait_cnt <= 0;
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
        end else if (mem_req) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= 0;
        end
    end

    // independent model: index 0-3 general, 4 address, 5 data
    logic [7:0] m_reg [6];
    logic [7:0] m_mem [256];

    typedef struct packed { logic bad; logic [7:0] data; } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per done cycle
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected done", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(illegal == e.bad, {t, " illegal flag"}, illegal, e.bad);
                check(xfer_data == e.data, {t, " xfer_data"}, xfer_data, e.data);
            end
        end
    end

    function automatic logic [7:0] src_val(input logic [2:0] s, input logic [7:0] imm);
        if (s < 6) return m_reg[s];
        return imm;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [2:0] sa, input logic [2:0] da,
                         input logic pr, input logic [2:0] sb, input logic [2:0] db,
                         input logic [7:0] imm, input string tag);
        exp_t e;
        int   lat;
        int   exp_lat;
        bit   bad;
        bad = (op == 2'd3) ||
              (op == 2'd0 && (sa == 3'd7 || da == 3'd6 || (pr && (sb != sa || db == 3'd6))));
        e.bad  = bad;
        e.data = '0;
        exp_lat = 1;
        if (!bad && op == 2'd0) begin
            e.data = src_val(sa, imm);
            if (da < 6) m_reg[da] = e.data;
            if (pr && db < 6) m_reg[db] = e.data;
        end else if (!bad && op == 2'd1) begin
            m_mem[m_reg[4]] = m_reg[5];
            e.data = m_reg[5];
            exp_lat = mem_wait + 2;
        end else if (!bad && op == 2'd2) begin
            m_reg[5] = m_mem[m_reg[4]];
            e.data = m_reg[5];
            exp_lat = mem_wait + 2;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cmd_valid = 1'b1; cmd_op = op; cmd_src_a = sa; cmd_dst_a = da;
        cmd_pair = pr; cmd_src_b = sb; cmd_dst_b = db; cmd_imm = imm;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        check(busy == 1'b0, {tag, " R8 busy cleared at done"}, busy, 0);
    endtask

    task automatic move(input logic [2:0] sa, input logic [2:0] da, input logic [7:0] imm,
                        input string tag);
        issue(2'd0, sa, da, 1'b0, 3'd0, 3'd7, imm, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = '0;
            m_mem[i] = '0;
        end
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && illegal == 0, "R1 control outputs after reset", {busy, done, illegal}, 0);
        check(xfer_data == 0, "R1 xfer_data after reset", xfer_data, 0);
        for (int i = 0; i < 6; i++) move(3'(i), 3'd7, 8'h00, "R1 R2 readback after reset");

        move(3'd6, 3'd0, 8'h3C, "R2 immediate to r0");
        issue(2'd0, 3'd6, 3'd1, 1'b1, 3'd6, 3'd2, 8'hA5, "R3 pair load r1 r2");
        move(3'd1, 3'd7, 8'h00, "R3 read r1");
        move(3'd2, 3'd7, 8'h00, "R3 read r2");
        issue(2'd0, 3'd0, 3'd4, 1'b1, 3'd0, 3'd3, 8'h00, "R3 r0 to AR and r3");
        move(3'd4, 3'd7, 8'h00, "R2 read AR");
        move(3'd3, 3'd7, 8'h00, "R2 read r3");
        move(3'd6, 3'd5, 8'h5A, "R2 immediate to DR");

        issue(2'd0, 3'd1, 3'd0, 1'b1, 3'd2, 3'd3, 8'h00, "R4 two sources");
        issue(2'd0, 3'd7, 3'd0, 1'b0, 3'd0, 3'd7, 8'hFF, "R4 reserved source");
        issue(2'd0, 3'd6, 3'd6, 1'b0, 3'd0, 3'd7, 8'hFF, "R4 reserved destination");
        issue(2'd3, 3'd6, 3'd0, 1'b0, 3'd0, 3'd7, 8'hFF, "R10 reserved op");
        move(3'd0, 3'd7, 8'h00, "R4 r0 unchanged");
        move(3'd3, 3'd7, 8'h00, "R4 r3 unchanged");

        mem_wait = 0;
        issue(2'd1, 3'd0, 3'd7, 1'b0, 3'd0, 3'd7, 8'h00, "R5 write no wait");
        mem_wait = 3;
        move(3'd6, 3'd4, 8'h10, "R5 AR setup");
        move(3'd6, 3'd5, 8'h77, "R5 DR setup");
        issue(2'd1, 3'd0, 3'd7, 1'b0, 3'd0, 3'd7, 8'h00, "R5 R7 write three waits");

        move(3'd6, 3'd4, 8'h3C, "R6 AR setup");
        move(3'd6, 3'd5, 8'h00, "R6 DR clear");
        mem_wait = 2;
        issue(2'd2, 3'd0, 3'd7, 1'b0, 3'd0, 3'd7, 8'h00, "R6 read two waits");
        move(3'd5, 3'd3, 8'h00, "R6 DR to r3");

        // R9: commands offered while busy are dropped
        mem_wait = 4;
        move(3'd6, 3'd4, 8'h10, "R9 AR setup");
        begin
            exp_t e;
            m_reg[5] = m_mem[8'h10];
            e.bad = 1'b0;
            e.data = m_reg[5];
            exp_q.push_back(e);
            tag_q.push_back("R9 read during busy burst");
            cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pair = 1'b0;
            @(negedge clk);
            check(busy == 1'b1, "R8 busy during access", busy, 1);
            cmd_op = 2'd0; cmd_src_a = 3'd6; cmd_dst_a = 3'd0; cmd_imm = 8'hEE;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
            while (busy) @(negedge clk);
            @(negedge clk);
        end
        move(3'd0, 3'd7, 8'h00, "R9 r0 not loaded while busy");
        move(3'd5, 3'd7, 8'h00, "R9 DR holds read value");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8 all expected completions seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule